// File: doc/BRIEF.md
# Telset Burst-Synchronised Frame Sequencer

This block sits in the telephone-set end of a two-wire ping-pong digital loop. The block runs from the local 4.096 MHz oscillator. Each time the demodulator reports a finished burst from the line card, the block starts a new frame. At that point it opens the codec transmit window, updates the received signaling and valid flags, and samples the local signaling inputs. It then shifts the demodulated voice byte to the codec. It also collects the codec's return byte and, a fixed delay later, asks the modulator to send the return burst.

The codec data clock is the oscillator divided by 32 and runs for exactly sixteen periods per frame. It then parks low until the next burst completes, so any drift between the two ends' crystals is absorbed once per frame.

When no burst arrives for 250 µs, the block drops the valid flag and its power request. If it is powered up, it then keeps its own 125 µs frame and sends a burst every second frame. With tone enable high it keeps the same frame without sending. In loopback, the demodulated voice byte is returned in place of the codec byte and the codec clock is held low.

Top module: `slave_frame_seq`

## Requirements
- R1: After reset, codec_clk_o, tx_en_o, tx_oe_o, so1_o, so2_o, valid_o, mod_start_o and pwr_req_o are 0 and rx_en_o is 1.
- R2: On the clock edge that samples demod_done_i high, the following outputs update together: tx_en_o goes 1 and rx_en_o goes 0, so1_o takes demod_word_i[8], so2_o takes demod_word_i[9], valid_o takes demod_valid_i, and pwr_req_o goes 1.
- R3: From that edge the codec clock has a period of OSC_DIV (32) cycles and is high for the first half of each period. It produces exactly 16 rising edges, the first one at the frame start, and then stays low until the next frame start.
- R4: During codec period p (p = 0..7), tx_data_o carries bit 7-p of the demodulated voice byte demod_word_i[7:0], most significant bit first. tx_oe_o equals tx_en_o.
- R5: At the ninth codec rising edge (256 cycles after frame start), tx_en_o falls and rx_en_o rises. rx_i is sampled on the next eight codec falling edges, most significant bit first, to form the codec return byte.
- R6: When pwr_up_i is 1 at frame start, mod_start_o is high for exactly one cycle, starting MOD_DELAY (64, four 256 kHz baud periods) edges after the frame-start edge. The matching mod_word_o holds {si2, si1, voice} in bits [9], [8] and [7:0]. The SI values are the ones sampled at the frame-start edge and later changes to them are ignored. With pwr_up_i at 0, no modulation start is issued.
- R7: Outside loopback, the voice field of mod_word_o is the codec byte collected in the previous frame (0 after reset).
- R8: With loopback_i high, codec_clk_o stays 0 and the voice field of mod_word_o is demod_word_i[7:0] of the current burst.
- R9: TIMEOUT_CYC (1024) cycles after the last demodulated burst, valid_o and pwr_req_o go to 0.
- R10: After the timeout, with pwr_up_i high, frames repeat every FRAME_CYC (512) cycles. A return burst is issued on every second frame with {si2, si1, last codec byte}, and so1_o, so2_o and valid_o are left unchanged.
- R11: After the timeout, with pwr_up_i low and tone_en_i high, frames still repeat every FRAME_CYC cycles with a full codec clock, but no return burst is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4.096 MHz oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| demod_done_i | input | 1 | One-cycle strobe when a received burst finishes demodulating |
| demod_word_i | input | 10 | Demodulated word: [9] signal 2, [8] signal 1, [7:0] voice |
| demod_valid_i | input | 1 | Burst had correct sync and no bit errors |
| si1_i | input | 1 | Local signaling bit 1 |
| si2_i | input | 1 | Local signaling bit 2 |
| rx_i | input | 1 | Serial voice data from the codec |
| loopback_i | input | 1 | Loopback request, active high |
| tone_en_i | input | 1 | Tone enable; keeps frames running without bursts |
| pwr_up_i | input | 1 | Level read back from the power control line, 1 = powered up |
| codec_clk_o | output | 1 | Gated 128 kHz codec data clock |
| tx_en_o | output | 1 | Transmit window to the codec |
| rx_en_o | output | 1 | Receive window from the codec, inverse of tx_en_o |
| tx_data_o | output | 1 | Serial voice data to the codec |
| tx_oe_o | output | 1 | Output enable for tx_data_o (drive when 1) |
| so1_o | output | 1 | Received signaling bit 1 |
| so2_o | output | 1 | Received signaling bit 2 |
| valid_o | output | 1 | Received burst valid flag |
| mod_start_o | output | 1 | One-cycle request to start the return burst |
| mod_word_o | output | 10 | Return word: [9] si2, [8] si1, [7:0] voice |
| pwr_req_o | output | 1 | Power request drive for the power control line |

## Verification
The bench goes after the frame edges where an off-by-one costs a bit. A design that stopped the codec clock at 15 or 17 periods would give the wrong rise count. A design that dropped the transmit window one period early or late would drop or duplicate a voice bit, or shift the captured return byte. It checks that the return word carries the byte from the previous frame, not a half-captured one, and that signaling inputs toggled just after the frame edge do not leak into the burst. In autonomous and tone frames it counts windows of exactly four frames. A design that bursted on every frame, bursted while powered down, or let the codec clock run in loopback would show the wrong number of bursts or clock edges.

// File: rtl/slave_frame_pkg.sv
package slave_frame_pkg;
  localparam int unsigned VOICE_W = 8;

  typedef struct packed {
    logic               sig2;
    logic               sig1;
    logic [VOICE_W-1:0] voice;
  } line_word_t;
endpackage

// File: rtl/sfs_frame_timer.sv
// Idle watchdog and autonomous frame generator.
module sfs_frame_timer #(
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter int unsigned FRAME_CYC   = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic demod_i,
  input  logic pwr_up_i,
  input  logic tone_i,
  output logic timeout_o,
  output logic tick_o,
  output logic burst_o
);
  localparam int unsigned IW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned FW = $clog2(FRAME_CYC);

  logic [IW-1:0] idle_q;
  logic [FW-1:0] fr_q;
  logic          par_q;
  logic          lost, free_run;

  assign lost      = (idle_q == IW'(TIMEOUT_CYC));
  assign free_run  = lost && (pwr_up_i || tone_i) && !demod_i;
  assign timeout_o = !demod_i && (idle_q == IW'(TIMEOUT_CYC - 1));
  assign tick_o    = free_run && (fr_q == FW'(FRAME_CYC - 1));
  assign burst_o   = tick_o && par_q && pwr_up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (demod_i) begin
      idle_q <= '0;
    end else if (!lost) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q  <= '0;
      par_q <= 1'b0;
    end else if (!free_run) begin
      fr_q  <= '0;
      par_q <= 1'b0;
    end else if (tick_o) begin
      fr_q  <= '0;
      par_q <= ~par_q;
    end else begin
      fr_q  <= fr_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfs_codec_seq.sv
// Gated codec clock and transmit/receive window sequencing.
module sfs_codec_seq #(
  parameter int unsigned DIV = 32,
  parameter int unsigned NTX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic loop_i,
  output logic codec_clk_o,
  output logic te_o,
  output logic shift_o,
  output logic sample_o,
  output logic last_o
);
  localparam int unsigned NPER = 2 * NTX;
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PW   = $clog2(DIV);
  localparam int unsigned NW   = $clog2(NPER);

  logic          run_q, te_q;
  logic [PW-1:0] ph_q;
  logic [NW-1:0] per_q;
  logic          ph_end;

  assign ph_end      = (ph_q == PW'(DIV - 1));
  assign codec_clk_o = run_q && (ph_q < PW'(HALF)) && !loop_i;
  assign te_o        = te_q;
  assign shift_o     = run_q && ph_end && (per_q < NW'(NTX - 1));
  assign sample_o    = run_q && (ph_q == PW'(HALF - 1)) && (per_q >= NW'(NTX));
  assign last_o      = sample_o && (per_q == NW'(NPER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      te_q  <= 1'b0;
      ph_q  <= '0;
      per_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      te_q  <= 1'b1;
      ph_q  <= '0;
      per_q <= '0;
    end else if (run_q) begin
      if (ph_end) begin
        ph_q <= '0;
        if (per_q == NW'(NPER - 1)) run_q <= 1'b0;
        else                        per_q <= per_q + 1'b1;
        if (per_q == NW'(NTX - 1))  te_q  <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfs_serial_io.sv
// Codec-side shift registers.
module sfs_serial_io #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         last_i,
  input  logic         rx_i,
  output logic         tx_bit_o,
  output logic [W-1:0] rx_word_o
);
  logic [W-1:0] tx_sh_q, rx_sh_q, rx_word_q;

  assign tx_bit_o  = tx_sh_q[W-1];
  assign rx_word_o = rx_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q <= load_val_i;
    end else if (shift_i) begin
      tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q   <= '0;
      rx_word_q <= '0;
    end else if (sample_i) begin
      rx_sh_q <= {rx_sh_q[W-2:0], rx_i};
      if (last_i) rx_word_q <= {rx_sh_q[W-2:0], rx_i};
    end
  end
endmodule

// File: rtl/sfs_burst_sched.sv
// Return burst delay and word assembly.
module sfs_burst_sched
  import slave_frame_pkg::*;
#(
  parameter int unsigned MOD_DELAY = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               loop_sel_i,
  input  logic               si1_i,
  input  logic               si2_i,
  input  logic [VOICE_W-1:0] demod_voice_i,
  input  logic [VOICE_W-1:0] rx_word_i,
  output logic               mod_start_o,
  output line_word_t         mod_word_o
);
  localparam int unsigned CW = $clog2(MOD_DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          start_q;
  line_word_t    word_q;

  assign mod_start_o = start_q;
  assign mod_word_o  = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
      word_q  <= '0;
    end else begin
      start_q <= (cnt_q == CW'(1));
      if (fire_i) begin
        cnt_q        <= CW'(MOD_DELAY);
        word_q.sig2  <= si2_i;
        word_q.sig1  <= si1_i;
        word_q.voice <= loop_sel_i ? demod_voice_i : rx_word_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/slave_frame_seq.sv
module slave_frame_seq
  import slave_frame_pkg::*;
#(
  parameter int unsigned OSC_DIV     = 32,
  parameter int unsigned MOD_BAUDS   = 4,
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter int unsigned FRAME_CYC   = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       demod_done_i,
  input  logic [9:0] demod_word_i,
  input  logic       demod_valid_i,
  input  logic       si1_i,
  input  logic       si2_i,
  input  logic       rx_i,
  input  logic       loopback_i,
  input  logic       tone_en_i,
  input  logic       pwr_up_i,
  output logic       codec_clk_o,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       tx_data_o,
  output logic       tx_oe_o,
  output logic       so1_o,
  output logic       so2_o,
  output logic       valid_o,
  output logic       mod_start_o,
  output logic [9:0] mod_word_o,
  output logic       pwr_req_o
);
  localparam int unsigned BAUD_DIV  = OSC_DIV / 2;
  localparam int unsigned MOD_DELAY = BAUD_DIV * MOD_BAUDS;

  line_word_t         dword, mword;
  logic               timeout, fr_tick, fr_burst, frame_start;
  logic               shift, sample, last, te;
  logic [VOICE_W-1:0] rx_word;
  logic               so1_q, so2_q, valid_q, preq_q;

  assign dword       = line_word_t'(demod_word_i);
  assign frame_start = demod_done_i || fr_tick;

  sfs_frame_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .FRAME_CYC  (FRAME_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .demod_i  (demod_done_i),
    .pwr_up_i (pwr_up_i),
    .tone_i   (tone_en_i),
    .timeout_o(timeout),
    .tick_o   (fr_tick),
    .burst_o  (fr_burst)
  );

  sfs_codec_seq #(
    .DIV(OSC_DIV),
    .NTX(VOICE_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (frame_start),
    .loop_i     (loopback_i),
    .codec_clk_o(codec_clk_o),
    .te_o       (te),
    .shift_o    (shift),
    .sample_o   (sample),
    .last_o     (last)
  );

  sfs_serial_io #(
    .W(VOICE_W)
  ) u_sio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (frame_start),
    .load_val_i(demod_done_i ? dword.voice : '0),
    .shift_i   (shift),
    .sample_i  (sample),
    .last_i    (last),
    .rx_i      (rx_i),
    .tx_bit_o  (tx_data_o),
    .rx_word_o (rx_word)
  );

  sfs_burst_sched #(
    .MOD_DELAY(MOD_DELAY)
  ) u_burst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       ((demod_done_i && pwr_up_i) || fr_burst),
    .loop_sel_i   (demod_done_i && loopback_i),
    .si1_i        (si1_i),
    .si2_i        (si2_i),
    .demod_voice_i(dword.voice),
    .rx_word_i    (rx_word),
    .mod_start_o  (mod_start_o),
    .mod_word_o   (mword)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so1_q   <= 1'b0;
      so2_q   <= 1'b0;
      valid_q <= 1'b0;
      preq_q  <= 1'b0;
    end else if (demod_done_i) begin
      so1_q   <= dword.sig1;
      so2_q   <= dword.sig2;
      valid_q <= demod_valid_i;
      preq_q  <= 1'b1;
    end else if (timeout) begin
      valid_q <= 1'b0;
      preq_q  <= 1'b0;
    end
  end

  assign tx_en_o    = te;
  assign rx_en_o    = ~te;
  assign tx_oe_o    = te;
  assign so1_o      = so1_q;
  assign so2_o      = so2_q;
  assign valid_o    = valid_q;
  assign pwr_req_o  = preq_q;
  assign mod_word_o = mword;
endmodule

// File: rtl/slave_frame_seq_chk.sv
module slave_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       demod_done_i,
  input logic [9:0] demod_word_i,
  input logic       demod_valid_i,
  input logic       loopback_i,
  input logic       frame_start,
  input logic       codec_clk_o,
  input logic       tx_en_o,
  input logic       so1_o,
  input logic       so2_o,
  input logic       valid_o,
  input logic       pwr_req_o,
  input logic       mod_start_o
);
  logic       clk_d, st_d, rise;
  logic [7:0] rise_cnt;

  assign rise = codec_clk_o && !clk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_d    <= 1'b0;
      st_d     <= 1'b0;
      rise_cnt <= '0;
    end else begin
      clk_d <= codec_clk_o;
      st_d  <= frame_start;
      if (st_d)             rise_cnt <= {7'd0, rise};
      else if (rise && rise_cnt != 8'hff) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_start_te_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_done_i |=> tx_en_o);

  p_start_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_done_i |=> (so1_o == $past(demod_word_i[8])) && (so2_o == $past(demod_word_i[9]))
                     && (valid_o == $past(demod_valid_i)) && pwr_req_o);

  p_clk_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt <= 8'd16);

  p_te_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_en_o) && !frame_start && !$past(frame_start) && !loopback_i) |-> codec_clk_o);

  p_mod_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_start_o |=> !mod_start_o);
endmodule

bind slave_frame_seq slave_frame_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .demod_done_i (demod_done_i),
  .demod_word_i (demod_word_i),
  .demod_valid_i(demod_valid_i),
  .loopback_i   (loopback_i),
  .frame_start  (frame_start),
  .codec_clk_o  (codec_clk_o),
  .tx_en_o      (tx_en_o),
  .so1_o        (so1_o),
  .so2_o        (so2_o),
  .valid_o      (valid_o),
  .pwr_req_o    (pwr_req_o),
  .mod_start_o  (mod_start_o)
);

// File: tb/slave_frame_seq_tb.sv
module slave_frame_seq_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       demod_done, demod_valid, si1, si2, rx, loopback, tone_en, pwr_up;
  logic [9:0] demod_word;
  logic       codec_clk, tx_en, rx_en, tx_data, tx_oe, so1, so2, valid, mod_start, pwr_req;
  logic [9:0] mod_word;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  slave_frame_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .demod_done_i(demod_done), .demod_word_i(demod_word),
    .demod_valid_i(demod_valid), .si1_i(si1), .si2_i(si2), .rx_i(rx),
    .loopback_i(loopback), .tone_en_i(tone_en), .pwr_up_i(pwr_up),
    .codec_clk_o(codec_clk), .tx_en_o(tx_en), .rx_en_o(rx_en), .tx_data_o(tx_data),
    .tx_oe_o(tx_oe), .so1_o(so1), .so2_o(so2), .valid_o(valid),
    .mod_start_o(mod_start), .mod_word_o(mod_word), .pwr_req_o(pwr_req)
  );

  // {loopback, si2, si1, valid, codec byte, demod word}
  localparam logic [21:0] VEC [4] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 10'h2A5},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'hC3, 10'h15A},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 10'h3FF},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h7E, 10'h000}
  };

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic run_frame(input logic [21:0] v, input logic [7:0] exp_voice);
    logic [9:0] w;
    logic [7:0] rxw;
    logic       lb, s1, s2, pclk;
    int         rises;
    w = v[9:0]; rxw = v[17:10]; lb = v[21]; s1 = v[19]; s2 = v[20];
    @(posedge clk); #2;
    demod_done = 1'b1; demod_word = w; demod_valid = v[18];
    si1 = s1; si2 = s2; loopback = lb;
    pclk = 1'b0; rises = 0;
    for (int n = 0; n < 512; n++) begin
      @(posedge clk); #2;
      if (codec_clk && !pclk) rises++;
      pclk = codec_clk;
      if (n == 0) begin
        demod_done = 1'b0;
        chk("R2 tx_en", tx_en, 1);
        chk("R2 rx_en", rx_en, 0);
        chk("R2 so1", so1, w[8]);
        chk("R2 so2", so2, w[9]);
        chk("R2 valid", valid, v[18]);
        chk("R2 pwr_req", pwr_req, 1);
      end
      if (n == 10) begin si1 = ~s1; si2 = ~s2; end
      if (n < 256 && n % 32 == 8) begin
        chk("R4 tx bit", tx_data, w[7 - n / 32]);
        chk("R4 tx_oe", tx_oe, 1);
      end
      if (n >= 256 && n % 32 == 4) rx = rxw[7 - (n - 256) / 32];
      if (n == 255) chk("R5 tx_en before ninth edge", tx_en, 1);
      if (n == 256) begin
        chk("R5 tx_en", tx_en, 0);
        chk("R5 rx_en", rx_en, 1);
        chk("R4 tx_oe off", tx_oe, 0);
      end
      if (n == 63 || n == 65) chk("R6 mod_start idle", mod_start, 0);
      if (n == 64) begin
        chk("R6 mod_start", mod_start, pwr_up);
        if (pwr_up) chk(lb ? "R8 mod_word" : "R7 mod_word", mod_word, {s2, s1, exp_voice});
      end
    end
    chk(lb ? "R8 codec clk held" : "R3 codec clk rises", rises, lb ? 0 : 16);
    chk("R3 codec clk parked", codec_clk, 0);
  endtask

  task automatic window(input string rq, input int exp_te, input int exp_clk,
                        input int exp_mod, input logic [9:0] exp_word);
    logic pte, pclk;
    int   te_r, clk_r, mod_n;
    pte = tx_en; pclk = codec_clk; te_r = 0; clk_r = 0; mod_n = 0;
    for (int n = 0; n < 2048; n++) begin
      @(posedge clk); #2;
      if (tx_en && !pte) te_r++;
      if (codec_clk && !pclk) clk_r++;
      pte = tx_en; pclk = codec_clk;
      if (mod_start) begin
        mod_n++;
        chk({rq, " burst word"}, mod_word, exp_word);
      end
    end
    chk({rq, " frames"}, te_r, exp_te);
    chk({rq, " codec rises"}, clk_r, exp_clk);
    chk({rq, " bursts"}, mod_n, exp_mod);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] prev_rx;
    rst_ni = 1'b0; demod_done = 1'b0; demod_word = '0; demod_valid = 1'b0;
    si1 = 1'b0; si2 = 1'b0; rx = 1'b0; loopback = 1'b0; tone_en = 1'b0; pwr_up = 1'b0;
    tick(3);
    chk("R1 codec_clk", codec_clk, 0);
    chk("R1 tx_en", tx_en, 0);
    chk("R1 rx_en", rx_en, 1);
    chk("R1 tx_oe", tx_oe, 0);
    chk("R1 so", {so2, so1}, 0);
    chk("R1 valid", valid, 0);
    chk("R1 mod_start", mod_start, 0);
    chk("R1 pwr_req", pwr_req, 0);
    rst_ni = 1'b1;
    tick(4);
    pwr_up = 1'b1;

    prev_rx = 8'h00;
    for (int i = 0; i < 4; i++) begin
      run_frame(VEC[i], VEC[i][21] ? VEC[i][7:0] : prev_rx);
      prev_rx = VEC[i][17:10];
    end

    // R9: idle timeout with power down
    pwr_up = 1'b0;
    tick(480);
    chk("R9 valid before timeout", valid, 1);
    chk("R9 pwr_req before timeout", pwr_req, 1);
    tick(40);
    chk("R9 valid after timeout", valid, 0);
    chk("R9 pwr_req after timeout", pwr_req, 0);
    chk("R9 no frame", tx_en, 0);

    // R10: autonomous powered frames
    pwr_up = 1'b1; si1 = 1'b0; si2 = 1'b1; rx = 1'b1;
    tick(600);
    window("R10", 4, 64, 2, 10'h2FF);
    chk("R10 valid untouched", valid, 0);
    chk("R10 so untouched", {so2, so1}, 2'b00);

    // R11: tone frames, no bursts
    pwr_up = 1'b0; tone_en = 1'b1;
    window("R11", 4, 64, 0, 10'h000);

    // R8: loopback suppresses the codec clock in tone frames
    loopback = 1'b1;
    window("R8 tone loop", 4, 0, 0, 10'h000);

    // R6: powered-down burst gives no modulation start
    loopback = 1'b0; tone_en = 1'b0; pwr_up = 1'b0;
    run_frame({1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 10'h1C3}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule